// File: doc/BRIEF.md
# Power domain state controller

This block sequences the power state of one switchable logic domain that holds a configurable number of memory banks. Software programs a target state (OFF or ON) and an optional low-power change request through a small register port. When the domain is asked to sleep, the block compares the target with the current state. If they differ, it runs a transition through a request/acknowledge handshake with an abstract power switch. When the domain is released from sleep while OFF, the block wakes it back to ON.

The status register reports the current state, a transition-in-progress flag, one state field for each memory bank, a constant logic-on bit and a debug field holding the last state entered. The status register is initialised only by cold reset, so its contents survive a warm reset. The control register is initialised by either reset.

A domain that entered sleep without changing state stays as it is when its target is later changed. A low-power change request lets that sleeping domain move down to OFF without waking first. The request bit clears itself.

Register map: control at address 0, status at address 1. Every other address reads 0.
- Control: bits [1:0] hold the target. Bit 4 is the low-power change request. Bank i has a read-only on-state field at bits [8+2i +: 2] that always reads 3.
- Status: bits [1:0] hold the current state. Bit 2 is logic-on and always reads 1. Bit 4 is the transition-in-progress flag. Bank i reports its state at bits [8+2i +: 2]. Bits [25:24] hold the last state entered.
- State encoding: 0 is OFF, 3 is ON, and codes 1 and 2 are reserved.

Top module: `pd_domain_ctl`

## Requirements
- R1: After cold reset the control register reads target 3, request bit 0 and all bank on-state fields 3 (0x0000FF03 with four banks). The status register reads current state 3, logic bit 1, in-progress 0, all banks 3 and last state 0 (0x0000FF07). sw_req is 0.
- R2: A control write with target code 0 or 3 updates the target. A write with code 1 or 2 leaves the target unchanged.
- R3: While sleep_req is 1 and the target differs from the current state, the block raises sw_req. sw_on shows the destination (1 for ON) and the in-progress bit reads 1. sw_req stays high until sw_ack is seen. In the cycle after the acknowledge edge, the current state and every bank read the destination code. The in-progress bit clears one cycle after sw_ack falls.
- R4: While the current state is OFF and sleep_req is 0, the block runs a wake transition with sw_on 1. The current state and all banks then read 3.
- R5: If sleep was entered with the target equal to the current state, a later target change while sleep_req stays 1 and the request bit is 0 starts no transition.
- R6: While asleep, a control write of target 0 with the request bit set starts a transition to OFF without waking. The request bit reads 1 until that transition completes and reads 0 afterwards.
- R7: When the target is 3, a set request bit reads 0 within two cycles of being written.
- R8: A control write made while a transition is in progress does not change the control register at once. It takes effect when the transition completes.
- R9: Completing a transition to OFF sets the last-state field to 0. A status write with 3 in bits [25:24] sets it to 3. Any other value written there leaves it unchanged.
- R10: A warm reset returns the control register to its reset value. The current state and last-state field are left untouched.
- R11: Reserved bits, unmapped addresses and the read-only fields read 0 or their fixed value, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Synchronous active-low cold reset, initialises everything |
| warm_rst_n | input | 1 | Synchronous active-low warm reset, initialises the control register only |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 control, 1 status) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from reg_addr |
| sleep_req | input | 1 | Domain sleep request |
| sw_ack | input | 1 | Power switch acknowledge |
| sw_req | output | 1 | Power switch request, held until acknowledged |
| sw_on | output | 1 | Requested switch state while sw_req is high (1 on, 0 off) |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, a 2-bit address and four memory banks. With four banks, every bank field fits below the last-state field, and fixed hexadecimal register images can be expected for each state. That makes every reserved bit between the fields visible in a single compare. The 2-bit address leaves two unmapped addresses, so the read-as-zero decode is reachable. Holding sw_ack back for several cycles exposes the handshake hold. It also gives a window in which control writes must be deferred.

// File: rtl/pd_pkg.sv
package pd_pkg;
   localparam logic [1:0] PS_OFF = 2'd0;
   localparam logic [1:0] PS_ON  = 2'd3;

   localparam int CTL_LP_BIT   = 4;
   localparam int ST_LOGIC_BIT = 2;
   localparam int ST_BUSY_BIT  = 4;
   localparam int BANK_LSB     = 8;
   localparam int ST_LAST_LSB  = 24;

   localparam int CTRL_ADDR = 0;
   localparam int STAT_ADDR = 1;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_REQ  = 2'd1,
      SQ_REL  = 2'd2
   } seq_state_e;

   function automatic logic code_ok(input logic [1:0] c);
      return (c == PS_OFF) || (c == PS_ON);
   endfunction
endpackage

// File: rtl/pd_ctl_reg.sv
module pd_ctl_reg
   import pd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [1:0] wr_tgt,
   input  logic       wr_lp,
   input  logic       busy,
   input  logic       done,
   output logic [1:0] tgt,
   output logic       lp
);
   logic       pend_v;
   logic [1:0] pend_tgt;
   logic       pend_lp;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tgt      <= PS_ON;
         lp       <= 1'b0;
         pend_v   <= 1'b0;
         pend_tgt <= PS_ON;
         pend_lp  <= 1'b0;
      end else if (done) begin
         pend_v <= 1'b0;
         lp     <= 1'b0;
         if (wr_en) begin
            if (code_ok(wr_tgt)) tgt <= wr_tgt;
            lp <= wr_lp;
         end else if (pend_v) begin
            tgt <= pend_tgt;
            lp  <= pend_lp;
         end
      end else if (wr_en && busy) begin
         pend_v   <= 1'b1;
         pend_lp  <= wr_lp;
         pend_tgt <= code_ok(wr_tgt) ? wr_tgt : (pend_v ? pend_tgt : tgt);
      end else if (wr_en) begin
         if (code_ok(wr_tgt)) tgt <= wr_tgt;
         lp <= wr_lp;
      end else if (tgt == PS_ON) begin
         lp <= 1'b0;
      end
   end

   p_tgt_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt == PS_OFF) || (tgt == PS_ON));

   p_lp_autoclear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lp && tgt == PS_ON && !wr_en && !done) |=> !lp);

   p_defer_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> $stable(tgt));
endmodule

// File: rtl/pd_seq.sv
module pd_seq
   import pd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sleep_req,
   input  logic       sw_ack,
   input  logic [1:0] tgt,
   input  logic       lp,
   input  logic [1:0] cur,
   output logic       sw_req,
   output logic       sw_on,
   output logic       busy,
   output logic       done,
   output logic       commit,
   output logic [1:0] dest
);
   seq_state_e state;
   logic       slept;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SQ_IDLE;
         slept <= 1'b0;
         dest  <= PS_ON;
      end else begin
         case (state)
            SQ_IDLE: begin
               if (sleep_req) begin
                  slept <= 1'b1;
                  if (!slept && tgt != cur) begin
                     dest  <= tgt;
                     state <= SQ_REQ;
                  end else if (slept && lp && tgt == PS_OFF && cur != PS_OFF) begin
                     dest  <= PS_OFF;
                     state <= SQ_REQ;
                  end
               end else begin
                  slept <= 1'b0;
                  if (cur == PS_OFF) begin
                     dest  <= PS_ON;
                     state <= SQ_REQ;
                  end
               end
            end
            SQ_REQ:  if (sw_ack)  state <= SQ_REL;
            SQ_REL:  if (!sw_ack) state <= SQ_IDLE;
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign sw_req = (state == SQ_REQ);
   assign sw_on  = (state == SQ_REQ) && (dest == PS_ON);
   assign busy   = (state != SQ_IDLE);
   assign commit = (state == SQ_REQ) && sw_ack;
   assign done   = (state == SQ_REL) && !sw_ack;

   p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_req && !sw_ack) |=> sw_req);

   p_no_wake_asleep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && sleep_req && slept && !lp && sleep_req) |=> !sw_req);
endmodule

// File: rtl/pd_status.sv
module pd_status
   import pd_pkg::*;
#(
   parameter int NUM_BANKS = 4
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   commit,
   input  logic [1:0]             dest,
   input  logic                   last_wr3,
   output logic [1:0]             cur,
   output logic [2*NUM_BANKS-1:0] bank_st,
   output logic [1:0]             last
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur  <= PS_ON;
         last <= PS_OFF;
      end else begin
         if (commit) cur <= dest;
         if (commit && dest == PS_OFF) last <= PS_OFF;
         else if (last_wr3)            last <= PS_ON;
      end
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [1:0] bank_q;
      always_ff @(posedge clk) begin
         if (!rst_n)      bank_q <= PS_ON;
         else if (commit) bank_q <= dest;
      end
      assign bank_st[2*b +: 2] = bank_q;
   end

   p_last_sw_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (last == PS_ON && $past(last) != PS_ON) |-> $past(last_wr3));
endmodule

// File: rtl/pd_domain_ctl.sv
module pd_domain_ctl
   import pd_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 2,
   parameter int NUM_BANKS = 4
)(
   input  logic              clk,
   input  logic              cold_rst_n,
   input  logic              warm_rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              sleep_req,
   input  logic              sw_ack,
   output logic              sw_req,
   output logic              sw_on
);
   localparam int BANK_BITS = 2 * NUM_BANKS;

   if (DATA_W < ST_LAST_LSB + 2) begin : g_bad_width
      $error("DATA_W too small for the status layout");
   end
   if (NUM_BANKS < 1 || BANK_LSB + BANK_BITS > ST_LAST_LSB) begin : g_bad_banks
      $error("NUM_BANKS must be 1 to 8");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be at least 1");
   end

   logic                 ctl_rst_n;
   logic                 ctl_wr, last_wr3;
   logic [1:0]           tgt, cur, last, dest;
   logic                 lp, busy, done, commit;
   logic [BANK_BITS-1:0] bank_st;
   logic                 unused_wdata;

   assign ctl_rst_n    = cold_rst_n & warm_rst_n;
   assign ctl_wr       = reg_we && (reg_addr == ADDR_W'(CTRL_ADDR));
   assign last_wr3     = reg_we && (reg_addr == ADDR_W'(STAT_ADDR)) &&
                         (reg_wdata[ST_LAST_LSB +: 2] == PS_ON);
   assign unused_wdata = ^reg_wdata;

   pd_ctl_reg i_ctl (
      .clk    (clk),
      .rst_n  (ctl_rst_n),
      .wr_en  (ctl_wr),
      .wr_tgt (reg_wdata[1:0]),
      .wr_lp  (reg_wdata[CTL_LP_BIT]),
      .busy   (busy),
      .done   (done),
      .tgt    (tgt),
      .lp     (lp)
   );

   pd_seq i_seq (
      .clk       (clk),
      .rst_n     (cold_rst_n),
      .sleep_req (sleep_req),
      .sw_ack    (sw_ack),
      .tgt       (tgt),
      .lp        (lp),
      .cur       (cur),
      .sw_req    (sw_req),
      .sw_on     (sw_on),
      .busy      (busy),
      .done      (done),
      .commit    (commit),
      .dest      (dest)
   );

   pd_status #(.NUM_BANKS(NUM_BANKS)) i_stat (
      .clk      (clk),
      .rst_n    (cold_rst_n),
      .commit   (commit),
      .dest     (dest),
      .last_wr3 (last_wr3),
      .cur      (cur),
      .bank_st  (bank_st),
      .last     (last)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(CTRL_ADDR)) begin
         reg_rdata[1:0]        = tgt;
         reg_rdata[CTL_LP_BIT] = lp;
         for (int b = 0; b < NUM_BANKS; b++) reg_rdata[BANK_LSB + 2*b +: 2] = PS_ON;
      end else if (reg_addr == ADDR_W'(STAT_ADDR)) begin
         reg_rdata[1:0]                  = cur;
         reg_rdata[ST_LOGIC_BIT]         = 1'b1;
         reg_rdata[ST_BUSY_BIT]          = busy;
         reg_rdata[BANK_LSB +: BANK_BITS] = bank_st;
         reg_rdata[ST_LAST_LSB +: 2]     = last;
      end
   end

   p_idle_no_req_r3: assert property (@(posedge clk) disable iff (!cold_rst_n)
      !busy |-> !sw_req);

   p_bank_match_r4: assert property (@(posedge clk) disable iff (!cold_rst_n)
      !busy |-> (bank_st == {NUM_BANKS{cur}}));
endmodule

// File: tb/test_pd_domain_ctl.sv
module test_pd_domain_ctl;
   logic        clk = 1'b0;
   logic        cold_rst_n = 1'b0, warm_rst_n = 1'b1;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        sleep_req = 1'b0, sw_ack = 1'b0;
   logic        sw_req, sw_on;
   int          checks = 0, errors = 0;
   bit          finished = 0;

   always #2.5 clk = ~clk;

   pd_domain_ctl i_pd_domain_ctl (
      .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .sleep_req(sleep_req), .sw_ack(sw_ack),
      .sw_req(sw_req), .sw_on(sw_on)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      step(1);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic chk_reg(input string req, input logic [1:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   task automatic hs_start(input string req, input logic exp_on, input logic [31:0] exp_st);
      int n = 0;
      while (!sw_req && n < 20) begin step(1); n++; end
      chk({req, " sw_req raised"}, {31'd0, sw_req}, 32'd1);
      chk({req, " sw_on"}, {31'd0, sw_on}, {31'd0, exp_on});
      step(3);
      chk({req, " sw_req held before ack"}, {31'd0, sw_req}, 32'd1);
      chk_reg({req, " status in transition"}, 2'd1, exp_st);
   endtask

   task automatic hs_finish(input string req, input logic [31:0] exp_mid, input logic [31:0] exp_end);
      sw_ack = 1'b1;
      step(1);
      chk_reg({req, " status after ack"}, 2'd1, exp_mid);
      sw_ack = 1'b0;
      step(1);
      chk_reg({req, " status after done"}, 2'd1, exp_end);
      chk({req, " sw_req dropped"}, {31'd0, sw_req}, 32'd0);
   endtask

   task automatic no_req(input string req, input int n);
      int seen = 0;
      for (int i = 0; i < n; i++) begin step(1); if (sw_req) seen++; end
      chk({req, " no switch request"}, seen, 0);
   endtask

   task automatic t_reset;
      chk_reg("R1 control reset", 2'd0, 32'h0000_FF03);
      chk_reg("R1 status reset", 2'd1, 32'h0000_FF07);
      chk("R1 sw_req reset", {31'd0, sw_req}, 32'd0);
   endtask

   task automatic t_reserved;
      chk_reg("R11 unmapped address 2", 2'd2, 32'h0);
      chk_reg("R11 unmapped address 3", 2'd3, 32'h0);
      wr(2'd0, 32'hFFFF_FFEB);
      chk_reg("R11 control reserved write", 2'd0, 32'h0000_FF03);
      wr(2'd1, 32'h00FF_FFFF);
      chk_reg("R11 status reserved write", 2'd1, 32'h0000_FF07);
   endtask

   task automatic t_codes;
      wr(2'd0, 32'h1);
      chk_reg("R2 code 1 ignored", 2'd0, 32'h0000_FF03);
      wr(2'd0, 32'h0);
      chk_reg("R2 code 0 accepted", 2'd0, 32'h0000_FF00);
      wr(2'd0, 32'h2);
      chk_reg("R2 code 2 ignored", 2'd0, 32'h0000_FF00);
      wr(2'd0, 32'h3);
      chk_reg("R2 code 3 accepted", 2'd0, 32'h0000_FF03);
   endtask

   task automatic t_sleep_off;
      wr(2'd0, 32'h0);
      sleep_req = 1'b1;
      hs_start("R3 sleep to OFF", 1'b0, 32'h0000_FF17);
      hs_finish("R3 sleep to OFF", 32'h0000_0014, 32'h0000_0004);
   endtask

   task automatic t_wake(input string req, input logic [31:0] pre, input logic [31:0] mid, input logic [31:0] post);
      sleep_req = 1'b0;
      hs_start(req, 1'b1, pre);
      hs_finish(req, mid, post);
   endtask

   task automatic t_last;
      wr(2'd1, 32'h0100_0000);
      chk_reg("R9 last write 1 ignored", 2'd1, 32'h0000_FF07);
      wr(2'd1, 32'h0300_0000);
      chk_reg("R9 last write 3 sets", 2'd1, 32'h0300_FF07);
   endtask

   task automatic t_hold_on;
      wr(2'd0, 32'h3);
      sleep_req = 1'b1;
      no_req("R5 sleep with target ON", 5);
      wr(2'd0, 32'h0);
      no_req("R5 target change without request", 6);
      chk_reg("R5 still ON", 2'd1, 32'h0300_FF07);
   endtask

   task automatic t_lp;
      wr(2'd0, 32'h10);
      chk_reg("R6 request bit set", 2'd0, 32'h0000_FF10);
      hs_start("R6 deeper state", 1'b0, 32'h0300_FF17);
      chk_reg("R6 request held during transition", 2'd0, 32'h0000_FF10);
      hs_finish("R6 R9 deeper state", 32'h0000_0014, 32'h0000_0004);
      chk_reg("R6 request cleared", 2'd0, 32'h0000_FF00);
   endtask

   task automatic t_lp_on;
      wr(2'd0, 32'h13);
      step(2);
      chk_reg("R7 request cleared with target ON", 2'd0, 32'h0000_FF03);
      no_req("R7 no wake while asleep", 3);
   endtask

   task automatic t_pending;
      wr(2'd0, 32'h0);
      sleep_req = 1'b1;
      hs_start("R8 transition", 1'b0, 32'h0000_FF17);
      wr(2'd0, 32'h3);
      chk_reg("R8 write deferred", 2'd0, 32'h0000_FF00);
      hs_finish("R8 transition", 32'h0000_0014, 32'h0000_0004);
      chk_reg("R8 write applied after completion", 2'd0, 32'h0000_FF03);
      no_req("R8 asleep after applied write", 4);
   endtask

   task automatic t_warm;
      wr(2'd0, 32'h0);
      sleep_req = 1'b1;
      hs_start("R10 prepare", 1'b0, 32'h0000_FF17);
      hs_finish("R10 prepare", 32'h0000_0014, 32'h0000_0004);
      wr(2'd1, 32'h0300_0000);
      wr(2'd0, 32'h10);
      chk_reg("R10 control before warm reset", 2'd0, 32'h0000_FF10);
      warm_rst_n = 1'b0;
      step(2);
      warm_rst_n = 1'b1;
      step(1);
      chk_reg("R10 control after warm reset", 2'd0, 32'h0000_FF03);
      chk_reg("R10 status kept", 2'd1, 32'h0300_0004);
      no_req("R10 stays OFF", 4);
   endtask

   initial begin
      step(3);
      cold_rst_n = 1'b1;
      step(1);
      t_reset();
      t_reserved();
      t_codes();
      t_sleep_off();
      t_wake("R4 wake", 32'h0000_0014, 32'h0000_FF17, 32'h0000_FF07);
      t_last();
      t_hold_on();
      t_lp();
      t_lp_on();
      t_wake("R4 wake after deeper state", 32'h0000_0014, 32'h0000_FF17, 32'h0000_FF07);
      t_pending();
      t_wake("R4 wake after pending", 32'h0000_0014, 32'h0000_FF17, 32'h0000_FF07);
      t_warm();
      t_wake("R4 R10 wake after warm reset", 32'h0300_0014, 32'h0300_FF17, 32'h0300_FF07);
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule